// File: doc/BRIEF.md
# Power-Management I/O Register Decoder

This block sits on an I/O bus and claims a 64-byte window whose position is set by a programmable base value. Inside that window it holds three 16-bit power-management registers: an event status register, an enable mask and a control word. Software reads and writes them with ordinary I/O accesses. The status register collects events signalled by hardware. A write to the status register clears bits instead of loading them.

Reads are combinational. The read data is valid in the same cycle that the read strobe and address are presented. Writes take effect at the next rising clock edge. The register contents are also driven out as ports. A level interrupt output reports any status bit whose enable bit is set.

Top module: `pm_io_decoder`

## Requirements
- R1: An access falls in the window when io_addr[15:6] equals pm_base[15:6]. pm_base[5:0] plays no part in the match, and the register offset is io_addr[5:0].
- R2: A read at offset 0x00 returns the status register in bits [15:0], with bits [31:16] equal to zero.
- R3: A write at offset 0x00 clears each status bit whose io_wdata[15:0] bit is 1 and leaves the other status bits unchanged.
- R4: A write at offset 0x02 loads the enable register from io_wdata[15:0]. A write at offset 0x04 loads the control register from io_wdata[15:0]. Bits [31:16] of the write data are discarded. Reads at these offsets return the register value zero-extended to 32 bits.
- R5: A read at any other offset, or at an address outside the window, returns 0xFFFFFFFF. While io_rd is low, rd_data is 0.
- R6: A write at any other offset, or at an address outside the window, changes no register.
- R7: After reset the status, enable and control registers are 0, and irq_lvl is low.
- R8: Each 1 on evt_set sets the matching status bit at the next clock edge. When an event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R9: irq_lvl is high exactly when the bitwise AND of status and enable is nonzero.
- R10: When pm_base changes, the old window stops responding and the new window responds, starting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 32 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| pm_base | input | 16 | Window base address; the low 6 bits are ignored |
| evt_set | input | 16 | Event pulses that set status bits |
| rd_data | output | 32 | Read data, valid in the same cycle as io_rd |
| sts_q | output | 16 | Status register |
| en_q | output | 16 | Enable register |
| ctl_q | output | 16 | Control register |
| irq_lvl | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an event arriving in the same cycle as a clear of the same status bit. The bench holds an event pulse and a status write across one shared clock edge, so that both act at once. It then checks that the contested bit stays set while the other bits named in the write are cleared. The bench also moves the base to a value whose low six bits are ones. It then checks that the old window returns all ones and ignores writes, while the new window reads and writes the registers that were already there.

// File: rtl/pm_io_decoder.sv
module pm_io_decoder #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int RW        = 16,
  parameter int WIN_BITS  = 6,
  parameter int STS_OFF   = 0,
  parameter int EN_OFF    = 2,
  parameter int CTL_OFF   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [AW-1:0] pm_base,
  input  logic [RW-1:0] evt_set,
  output logic [DW-1:0] rd_data,
  output logic [RW-1:0] sts_q,
  output logic [RW-1:0] en_q,
  output logic [RW-1:0] ctl_q,
  output logic          irq_lvl
);

  localparam int TAG_W = AW - WIN_BITS;

  logic                win_hit;
  logic [WIN_BITS-1:0] offs;
  logic                sel_sts, sel_en, sel_ctl;
  logic [RW-1:0]       wval;
  logic [RW-1:0]       clr_mask;

  assign win_hit  = io_addr[AW-1:WIN_BITS] == pm_base[AW-1:WIN_BITS];
  assign offs     = io_addr[WIN_BITS-1:0];
  assign sel_sts  = win_hit && (offs == WIN_BITS'(STS_OFF));
  assign sel_en   = win_hit && (offs == WIN_BITS'(EN_OFF));
  assign sel_ctl  = win_hit && (offs == WIN_BITS'(CTL_OFF));
  assign wval     = io_wdata[RW-1:0];
  assign clr_mask = (io_wr && sel_sts) ? wval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_mask) | evt_set;
      if (io_wr && sel_en)  en_q  <= wval;
      if (io_wr && sel_ctl) ctl_q <= wval;
    end
  end

  always_comb begin
    if (!io_rd)       rd_data = '0;
    else if (sel_sts) rd_data = DW'(sts_q);
    else if (sel_en)  rd_data = DW'(en_q);
    else if (sel_ctl) rd_data = DW'(ctl_q);
    else              rd_data = '1;
  end

  assign irq_lvl = |(sts_q & en_q);

  // R8
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_hit && offs == WIN_BITS'(STS_OFF) && evt_set == '0)
      |=> (sts_q == ($past(sts_q) & ~$past(io_wdata[RW-1:0]))));

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_hit && offs == WIN_BITS'(EN_OFF)) |=> (en_q == $past(io_wdata[RW-1:0])));

  // R6
  miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !win_hit) |=> ($stable(en_q) && $stable(ctl_q)));

  // R5
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (rd_data == '0));

endmodule

// File: tb/pm_io_decoder_tb_top.sv
module pm_io_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] pm_base = 16'h0400;
  logic [15:0] evt_set = '0;
  logic [31:0] rd_data;
  logic [15:0] sts_q, en_q, ctl_q;
  logic        irq_lvl;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_io_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .pm_base(pm_base), .evt_set(evt_set),
    .rd_data(rd_data), .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q),
    .irq_lvl(irq_lvl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [31:0] d, input logic wr,
                           input logic [15:0] ev);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = wr; evt_set = ev;
    @(negedge clk);
    io_wr = 1'b0; evt_set = '0;
    #1;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(req, rd_data, exp);
    io_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 sts", 32'(sts_q), 32'h0);
    check("R7 en", 32'(en_q), 32'h0);
    check("R7 ctl", 32'(ctl_q), 32'h0);
    check("R7 irq", 32'(irq_lvl), 32'h0);
    check("R5 idle rd", rd_data, 32'h0);
    rd_chk(16'h0400, 32'h0, "R2 status read after reset");
  endtask

  task automatic t_en_ctl();
    bus_cycle(16'h0402, 32'hABCD_1234, 1'b1, '0);
    check("R4 en", 32'(en_q), 32'h1234);
    rd_chk(16'h0402, 32'h0000_1234, "R4 en read");
    bus_cycle(16'h0404, 32'h5555_FFFF, 1'b1, '0);
    check("R4 ctl", 32'(ctl_q), 32'hFFFF);
    rd_chk(16'h0404, 32'h0000_FFFF, "R4 ctl read");
  endtask

  task automatic t_events();
    bus_cycle(16'h0000, 32'h0, 1'b0, 16'h00F3);
    check("R8 set", 32'(sts_q), 32'h00F3);
    rd_chk(16'h0400, 32'h0000_00F3, "R2 status read");
    check("R9 irq high", 32'(irq_lvl), 32'h1);
  endtask

  task automatic t_w1c();
    bus_cycle(16'h0400, 32'hFFFF_0031, 1'b1, '0);
    check("R3 clear", 32'(sts_q), 32'h00C2);
    check("R9 irq low", 32'(irq_lvl), 32'h0);
  endtask

  task automatic t_collide();
    bus_cycle(16'h0400, 32'h0000_0082, 1'b1, 16'h0002);
    check("R8 set wins", 32'(sts_q), 32'h0042);
  endtask

  task automatic t_unimpl();
    rd_chk(16'h0401, 32'hFFFF_FFFF, "R5 odd offset");
    rd_chk(16'h0406, 32'hFFFF_FFFF, "R5 offset 6");
    rd_chk(16'h043F, 32'hFFFF_FFFF, "R5 last offset");
    rd_chk(16'h0800, 32'hFFFF_FFFF, "R5 outside");
    bus_cycle(16'h0802, 32'h0000_0001, 1'b1, '0);
    check("R6 outside write en", 32'(en_q), 32'h1234);
    bus_cycle(16'h0403, 32'h0000_0002, 1'b1, '0);
    check("R6 offset 3 write en", 32'(en_q), 32'h1234);
    bus_cycle(16'h0406, 32'h0000_0003, 1'b1, '0);
    check("R6 offset 6 write ctl", 32'(ctl_q), 32'hFFFF);
  endtask

  task automatic t_move();
    @(negedge clk);
    pm_base = 16'hB03F;
    rd_chk(16'h0402, 32'hFFFF_FFFF, "R10 old window");
    rd_chk(16'hB002, 32'h0000_1234, "R10 new window R1 low base bits");
    bus_cycle(16'h0404, 32'h0000_0011, 1'b1, '0);
    check("R10 old write ignored", 32'(ctl_q), 32'hFFFF);
    bus_cycle(16'hB004, 32'h0000_00AA, 1'b1, '0);
    check("R10 new write", 32'(ctl_q), 32'h00AA);
    rd_chk(16'hB000, 32'h0000_0042, "R1 status in new window");
  endtask

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_en_ctl();
    t_events();
    t_w1c();
    t_collide();
    t_unimpl();
    t_move();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule